// File: doc/BRIEF.md
# Converter Clock Divider and Data-Ready Pulse Generator

This block sits beside the modulators and decimation filters of a multi-channel delta-sigma converter and turns the master clock into three single-cycle clock enables. The first is the analog modulator enable, which is the master clock divided by a selectable prescale factor. The second is the sample enable, which is the analog enable divided by a fixed four. The third is the conversion-complete enable, which is the sample enable divided by the selected oversampling ratio. All three are one master-clock cycle wide and are issued from registers, so downstream logic can use them as clock enables on the master clock domain.

Each conversion-complete event starts an active-low pulse on three data-ready pins, one for each channel pair. A pulse lasts exactly one sample period and ends by itself. No host action is involved. A pair whose two channels are both shut down gives no pulse. Each pin is presented as a drive value and an output enable. When idle, the pins either drive high or release to high impedance, depending on a single select input.

Top module: `conv_clock_ready`

## Requirements
- R1: `amclkEn` is high for one cycle every P master cycles, where `prescaleSel` 0,1,2,3 gives P = 1,2,4,8. The first strobe comes P cycles after reset is released.
- R2: `dmclkEn` is high for one cycle on every fourth `amclkEn` strobe, that is every 4·P master cycles, and only in a cycle where `amclkEn` is also high.
- R3: `drclkEn` is high for one cycle on every N-th `dmclkEn` strobe, that is every 4·P·N master cycles. `osrSel` 0,1,2,3 gives N = 32,64,128,256. It is high only in a cycle where `dmclkEn` is also high.
- R4: In the cycle after a `drclkEn` strobe, the data-ready value bits of the pulsing pairs go to 0. They stay at 0 for exactly 4·P master cycles and then return to 1 with no input activity.
- R5: While a data-ready value bit is 0, its output enable is 1, whatever the idle select is.
- R6: When no pulse is active, `readyOe` equals `idleDrive` replicated on every pin and `readyVal` is all ones. This means the pins drive high when `idleDrive`=1 and float when `idleDrive`=0.
- R7: Pair p (p = 0,1,2 on bit p of the pin buses) owns shutdown bits `chanOff[2p]` and `chanOff[2p+1]`. The pair gives no pulse only when both of those bits are 1. A single shut-down channel does not suppress the pulse.
- R8: While `rstN` is low, all three enables are 0, every `readyVal` bit is 1, `readyOe` follows R6, and all dividers restart from their initial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescaleSel | input | 2 | Prescale code (1,2,4,8) |
| osrSel | input | 2 | Oversampling code (32,64,128,256) |
| chanOff | input | 6 | Per-channel shutdown, two bits per pair |
| idleDrive | input | 1 | 1: idle pins driven high, 0: idle pins high impedance |
| amclkEn | output | 1 | Modulator clock enable strobe |
| dmclkEn | output | 1 | Sample clock enable strobe |
| drclkEn | output | 1 | Conversion-complete strobe |
| readyVal | output | 3 | Data-ready drive value per pair, active low |
| readyOe | output | 3 | Data-ready output enable per pair |

## Verification
The bench builds the block with its default widths: three pairs, 2-bit prescale and oversampling codes, and a 32 minimum ratio. Its runs together visit every prescale code and every oversampling code. This covers data-rate periods from 128 master cycles up to 8192, and pulse widths from 4 cycles up to 32. Shutdown patterns cover no pair suppressed, one pair suppressed, two pairs suppressed, and single channels off inside a pair, under both idle modes.

// File: rtl/convclk_pkg.sv
package convclk_pkg;
  // code widths of the two rate selectors
  localparam int PRE_W        = 2;
  localparam int OSR_W        = 2;
  // smallest oversampling ratio as a power of two
  localparam int OSR_MIN_LOG2 = 5;
  // fixed divide between modulator clock and sample clock, as a power of two
  localparam int DM_DIV_LOG2  = 2;
  localparam int NUM_PAIRS    = 3;
  localparam int CH_PER_PAIR  = 2;

  localparam int PRE_MAX_LOG2 = (1 << PRE_W) - 1;
  localparam int PRE_CNT_W    = (PRE_MAX_LOG2 > 0) ? PRE_MAX_LOG2 : 1;
  localparam int DM_CNT_W     = DM_DIV_LOG2;
  localparam int OSR_CNT_W    = OSR_MIN_LOG2 + (1 << OSR_W) - 1;
  localparam int PULSE_W      = DM_DIV_LOG2 + PRE_MAX_LOG2;
  localparam int NUM_CH       = NUM_PAIRS * CH_PER_PAIR;

  // command from control to the pin datapath
  typedef struct packed {
    logic               start;
    logic [PULSE_W-1:0] lenM1;
  } pulse_cmd_t;
endpackage

// File: rtl/convclk_divstage.sv
module convclk_divstage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  input  logic [W-1:0] lastCount,
  output logic         tick
);
  logic [W-1:0] cnt;

  // >= lets a shrinking terminal count wrap at once instead of running long
  assign tick = advance && (cnt >= lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/convclk_ctrl.sv
module convclk_ctrl
  import convclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescaleSel,
  input  logic [OSR_W-1:0] osrSel,
  output logic             amclkEn,
  output logic             dmclkEn,
  output logic             drclkEn,
  output pulse_cmd_t       pulseCmd
);
  logic [PRE_CNT_W-1:0] preLast;
  logic [OSR_CNT_W-1:0] osrLast;
  logic [PULSE_W-1:0]   lenM1Now;
  logic amNow, dmNow, drNow;
  logic amQ, dmQ, drQ;
  logic [PULSE_W-1:0]   lenQ;

  // terminal counts are runs of ones whose length follows the codes
  always_comb begin
    for (int i = 0; i < PRE_CNT_W; i++) preLast[i] = (i < int'(prescaleSel));
    for (int i = 0; i < OSR_CNT_W; i++) osrLast[i] = (i < OSR_MIN_LOG2 + int'(osrSel));
    for (int i = 0; i < PULSE_W; i++)   lenM1Now[i] = (i < DM_DIV_LOG2 + int'(prescaleSel));
  end

  convclk_divstage #(.W(PRE_CNT_W)) preStage (
    .clk(clk), .rstN(rstN), .advance(1'b1), .lastCount(preLast), .tick(amNow)
  );

  convclk_divstage #(.W(DM_CNT_W)) quarterStage (
    .clk(clk), .rstN(rstN), .advance(amNow), .lastCount({DM_CNT_W{1'b1}}), .tick(dmNow)
  );

  convclk_divstage #(.W(OSR_CNT_W)) osrStage (
    .clk(clk), .rstN(rstN), .advance(dmNow), .lastCount(osrLast), .tick(drNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      amQ  <= 1'b0;
      dmQ  <= 1'b0;
      drQ  <= 1'b0;
      lenQ <= '0;
    end else begin
      amQ  <= amNow;
      dmQ  <= dmNow;
      drQ  <= drNow;
      if (drNow) lenQ <= lenM1Now;
    end
  end

  assign amclkEn        = amQ;
  assign dmclkEn        = dmQ;
  assign drclkEn        = drQ;
  assign pulseCmd.start = drQ;
  assign pulseCmd.lenM1 = lenQ;
endmodule

// File: rtl/convclk_datapath.sv
module convclk_datapath
  import convclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pulse_cmd_t           pulseCmd,
  input  logic [NUM_CH-1:0]    chanOff,
  input  logic                 idleDrive,
  output logic [NUM_PAIRS-1:0] readyVal,
  output logic [NUM_PAIRS-1:0] readyOe
);
  logic               busy;
  logic [PULSE_W-1:0] remain;
  logic               pulseDone;

  assign pulseDone = busy && (remain == '0);

  // one shared width counter: pulses of all pairs start and stop together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (pulseCmd.start) begin
      busy   <= 1'b1;
      remain <= pulseCmd.lenM1;
    end else if (busy) begin
      if (pulseDone) busy <= 1'b0;
      else           remain <= remain - 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic lowQ;
    logic pairAwake;

    assign pairAwake = ~(&chanOff[p*CH_PER_PAIR +: CH_PER_PAIR]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               lowQ <= 1'b0;
      else if (pulseCmd.start) lowQ <= pairAwake;
      else if (pulseDone)      lowQ <= 1'b0;
    end

    assign readyVal[p] = ~lowQ;
    assign readyOe[p]  = lowQ | idleDrive;
  end
endmodule

// File: rtl/conv_clock_ready.sv
module conv_clock_ready (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] prescaleSel,
  input  logic [1:0] osrSel,
  input  logic [5:0] chanOff,
  input  logic       idleDrive,
  output logic       amclkEn,
  output logic       dmclkEn,
  output logic       drclkEn,
  output logic [2:0] readyVal,
  output logic [2:0] readyOe
);
  import convclk_pkg::*;

  pulse_cmd_t pulseCmd;

  convclk_ctrl ctrl (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .osrSel(osrSel),
    .amclkEn(amclkEn), .dmclkEn(dmclkEn), .drclkEn(drclkEn), .pulseCmd(pulseCmd)
  );

  convclk_datapath datapath (
    .clk(clk), .rstN(rstN), .pulseCmd(pulseCmd), .chanOff(chanOff),
    .idleDrive(idleDrive), .readyVal(readyVal), .readyOe(readyOe)
  );
endmodule

// File: rtl/conv_clock_ready_chk.sv
module conv_clock_ready_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] prescaleSel,
  input logic [5:0] chanOff,
  input logic       amclkEn,
  input logic       dmclkEn,
  input logic       drclkEn,
  input logic [2:0] readyVal,
  input logic [2:0] readyOe
);
  logic [3:0] gap;
  logic [3:0] expGap;
  logic [1:0] prevPre;
  logic       cfgClean;
  logic [2:0] awake;

  always_comb begin
    expGap = (4'd1 << prescaleSel) - 4'd1;
    for (int p = 0; p < 3; p++) awake[p] = ~(chanOff[2*p] & chanOff[2*p+1]);
  end

  // cycles since the last modulator strobe, valid once a strobe was seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap      <= '0;
      prevPre  <= '0;
      cfgClean <= 1'b0;
    end else begin
      gap      <= amclkEn ? 4'd0 : gap + 4'd1;
      prevPre  <= prescaleSel;
      cfgClean <= (prescaleSel == prevPre) && (amclkEn || cfgClean);
    end
  end

  assert_am_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    (amclkEn && cfgClean) |-> (gap == expGap));

  assert_dm_on_am_R2: assert property (@(posedge clk) disable iff (!rstN)
    dmclkEn |-> amclkEn);

  assert_dr_on_dm_R3: assert property (@(posedge clk) disable iff (!rstN)
    drclkEn |-> dmclkEn);

  assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    drclkEn |=> ((~readyVal) == $past(awake)));

  assert_low_driven_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((~readyVal) & (~readyOe)) == 3'b000);
endmodule

bind conv_clock_ready conv_clock_ready_chk chk (
  .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .chanOff(chanOff),
  .amclkEn(amclkEn), .dmclkEn(dmclkEn), .drclkEn(drclkEn),
  .readyVal(readyVal), .readyOe(readyOe)
);

// File: tb/conv_clock_ready_test.sv
`timescale 1ns/1ps
module conv_clock_ready_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] prescaleSel = '0;
  logic [1:0] osrSel = '0;
  logic [5:0] chanOff = '0;
  logic       idleDrive = 1'b0;
  logic       amclkEn, dmclkEn, drclkEn;
  logic [2:0] readyVal, readyOe;

  always #2 clk = ~clk;

  conv_clock_ready uut (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .osrSel(osrSel),
    .chanOff(chanOff), .idleDrive(idleDrive), .amclkEn(amclkEn),
    .dmclkEn(dmclkEn), .drclkEn(drclkEn), .readyVal(readyVal), .readyOe(readyOe)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 1'b0;
  int curP = 1, curOsr = 32;
  logic [2:0] curAwake = 3'b111;
  int drExpQ[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (running) cyc <= cyc + 1;

  // monitor: pops scheduled conversion strobes and compares pin waveforms
  always @(negedge clk) begin
    if (running && cyc > 0) begin
      int per;
      bit inLow;
      logic [2:0] lowExp;
      per = 4 * curP * curOsr;
      check(amclkEn == ((cyc % curP) == 0), "R1", "amclkEn", amclkEn, (cyc % curP) == 0);
      check(dmclkEn == ((cyc % (4*curP)) == 0), "R2", "dmclkEn", dmclkEn, (cyc % (4*curP)) == 0);
      if (drclkEn) begin
        if (drExpQ.size() == 0) check(1'b0, "R3", "unscheduled drclkEn at cycle", cyc, -1);
        else begin
          int e;
          e = drExpQ.pop_front();
          check(e == cyc, "R3", "drclkEn cycle", cyc, e);
        end
      end
      inLow  = (cyc - 1 >= per) && (((cyc - 1) % per) < 4 * curP);
      lowExp = inLow ? curAwake : 3'b000;
      check(readyVal == ~lowExp, "R4 R7", "readyVal", readyVal, ~lowExp);
      check(readyOe == (lowExp | {3{idleDrive}}), "R5 R6", "readyOe", readyOe, lowExp | {3{idleDrive}});
    end
  end

  // driver: resets, applies a setting, schedules the expected strobes
  task automatic runCfg(logic [1:0] pre, logic [1:0] osr, logic [5:0] off, logic idle, int nDr);
    int per;
    @(negedge clk);
    running = 1'b0;
    rstN = 1'b0;
    prescaleSel = pre;
    osrSel = osr;
    chanOff = off;
    idleDrive = idle;
    curP = 1 << pre;
    curOsr = 32 << osr;
    for (int p = 0; p < 3; p++) curAwake[p] = !(off[2*p] && off[2*p+1]);
    cyc = 0;
    drExpQ.delete();
    repeat (3) @(negedge clk);
    check({amclkEn, dmclkEn, drclkEn} == 3'b000, "R8", "enables in reset", {amclkEn, dmclkEn, drclkEn}, 0);
    check(readyVal == 3'b111, "R8", "readyVal in reset", readyVal, 7);
    check(readyOe == {3{idle}}, "R6 R8", "readyOe in reset", readyOe, {3{idle}});
    per = 4 * curP * curOsr;
    for (int k = 1; k <= nDr; k++) drExpQ.push_back(k * per);
    rstN = 1'b1;
    running = 1'b1;
    repeat (nDr * per + 4 * curP + 4) @(negedge clk);
    check(drExpQ.size() == 0, "R3", "missing drclkEn strobes", drExpQ.size(), 0);
    @(posedge clk);
    running = 1'b0;
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    // R1 R2 R3 R4: fastest setting, all pairs awake, floating idle
    runCfg(2'b00, 2'b00, 6'b000000, 1'b0, 3);
    // R7: pair 0 fully shut down, driven-high idle (R6)
    runCfg(2'b01, 2'b01, 6'b000011, 1'b1, 2);
    // R7: single channels off in pairs 1 and 2 keep their pulses; slowest setting
    runCfg(2'b11, 2'b11, 6'b010100, 1'b0, 2);
    // R7: pairs 1 and 2 shut down, driven idle
    runCfg(2'b10, 2'b10, 6'b111100, 1'b1, 2);
    // R3: largest ratio at smallest prescale, pair 2 shut down
    runCfg(2'b00, 2'b11, 6'b110000, 1'b0, 2);
    finishRun();
  end
endmodule